// File: doc/BRIEF.md
# Reset-Time Configuration Strap Sampler

This block reads configuration straps from pins that are shared with run-time signals. While the reset input is high it samples the pin bundle on every rising clock edge. The sample taken at the last edge of reset becomes the held configuration, and it stays fixed until reset is asserted again. From that word the block decodes a 3-bit configuration code, three driver-strength selects, a snoop mode, a write-ordering mode, a self-test request, a global tristate request, the memory-bus I/O width, a transfers-per-line select, the parity mode and a memory-bus timing mode. It also raises a configuration-error flag when two processor-side inputs hold an illegal level during reset.

The memory-bus timing strap is read by its activity rather than by its level. If the pin changes between any two consecutive reset samples, the bus is in clocked mode. Downstream logic receives a run-time view of the whole bundle. That view is held at a per-pin inactive level until the first rising edge after reset ends, which is the handover edge. After that edge it follows the pins.

Top module: `strap_sampler`

## Requirements
- R1: `cfg_code` equals bits [2:0] of the pin bundle as sampled at the last rising edge with `rst` high.
- R2: From the first edge of a reset until the first rising edge with `rst` low, `run_pins_o` equals the parameter `INACT_LVL` (default 16'h7FFF). After that edge it equals `pins_i` combinationally in the default variant.
- R3: `weak_order` is 1 exactly when held bit 6 is low.
- R4: `selftest_req` is 1 exactly when held bit 7 is low and held bit 8 is high.
- R5: `tristate_req` is 1 exactly when held bits 7 and 8 are both low.
- R6: `mbus_clocked` is 1 if bit 11 differs between any two consecutive samples within one reset. Otherwise it is the inverse of the held bit 11, so a steady high level gives strobed mode (0).
- R7: `drv_core`, `drv_addr` and `drv_data` equal held bits 3, 4 and 12. `snoop_mode` equals held bit 5. `io_x4` equals held bit 9. `xfer_sel` equals held bit 10. `parity_mode` is the inverse of held bit 13.
- R8: `cfg_err` is 1 when held bit 14 is high or held bit 15 is low.
- R9: After the handover edge, every configuration output stays unchanged while the pins change, until the next reset.
- R10: Each new reset starts toggle detection afresh. A toggle seen during an earlier reset has no effect on `mbus_clocked` after a later reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset; straps are sampled while it is high |
| pins_i | input | N_PIN | Shared strap / run-time pin bundle |
| run_pins_o | output | N_PIN | Run-time view of the pins, held inactive until handover |
| cfg_code | output | 3 | Operating configuration code |
| drv_core | output | 1 | Controller-to-SRAM buffer strength select |
| drv_addr | output | 1 | Memory address bus strength select |
| drv_data | output | 1 | Memory data bus strength select |
| snoop_mode | output | 1 | Snooping mode select |
| weak_order | output | 1 | Weak write ordering enabled |
| selftest_req | output | 1 | Self-test requested |
| tristate_req | output | 1 | Global tristate requested |
| io_x4 | output | 1 | Four memory-bus I/O pins per device when 1, eight when 0 |
| xfer_sel | output | 1 | Transfers-per-line select |
| parity_mode | output | 1 | Parity storage mode |
| mbus_clocked | output | 1 | Memory bus clocked (1) or strobed (0) |
| cfg_err | output | 1 | Illegal check or flush level during reset |

## Verification
Two things happen in the cycle in which reset falls: the held configuration freezes, and the run-time view is released on the next edge. The bench drops reset between edges. It then checks that the run-time view is still inactive and the fields already hold the final sample, and that one edge later the view tracks the pins while the fields do not move when the pins are inverted. The toggle detector and the level decode also meet in one sample. Vectors that toggle the timing strap mid-reset and end high have to read as clocked. A following reset with a steady high level has to read as strobed again.

// File: rtl/strap_pkg.sv
package strap_pkg;

   // number of pins that carry a strap meaning
   localparam int PIN_MIN   = 16;

   // strap bit positions inside the pin bundle
   localparam int B_CFG_LO  = 0;
   localparam int B_CFG_W   = 3;
   localparam int B_DRV_C   = 3;
   localparam int B_DRV_A   = 4;
   localparam int B_SNOOP   = 5;
   localparam int B_WORD_N  = 6;
   localparam int B_STEST_N = 7;
   localparam int B_HIZ_N   = 8;
   localparam int B_X4      = 9;
   localparam int B_XFER    = 10;
   localparam int B_MBUS    = 11;
   localparam int B_DRV_D   = 12;
   localparam int B_PAR_N   = 13;
   localparam int B_CHK     = 14;
   localparam int B_FLUSH   = 15;

   typedef struct packed {
      logic [B_CFG_W-1:0] cfg_code;
      logic drv_core;
      logic drv_addr;
      logic drv_data;
      logic snoop_mode;
      logic weak_order;
      logic selftest_req;
      logic tristate_req;
      logic io_x4;
      logic xfer_sel;
      logic parity_mode;
      logic mbus_clocked;
      logic cfg_err;
   } strap_cfg_t;

endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] pins_i,
   output logic [W-1:0] held_o
);

   // one sampling cell per strap pin; loads on every reset edge
   for (genvar i = 0; i < W; i++) begin : g_cell
      logic cell_q;
      always_ff @(posedge clk) begin
         if (rst) cell_q <= pins_i[i];
      end
      assign held_o[i] = cell_q;
   end

endmodule

// File: rtl/strap_activity.sv
module strap_activity (
   input  logic clk,
   input  logic rst,
   input  logic live_i,
   input  logic pin_i,
   output logic toggled_o
);

   logic prev_q;
   logic tog_q;

   // live_i high on a reset edge marks the first sample of a new reset
   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= pin_i;
         if (live_i) tog_q <= 1'b0;
         else        tog_q <= tog_q | (pin_i ^ prev_q);
      end
   end

   assign toggled_o = tog_q;

endmodule

// File: rtl/strap_handover.sv
module strap_handover #(
   parameter int         N_PIN     = 16,
   parameter logic [N_PIN-1:0] INACT_LVL = '1,
   parameter bit         RUN_REG   = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_PIN-1:0] pins_i,
   output logic             live_o,
   output logic [N_PIN-1:0] run_o
);

   logic live_q;

   always_ff @(posedge clk) begin
      live_q <= ~rst;
   end

   assign live_o = live_q;

   if (RUN_REG) begin : g_reg
      logic [N_PIN-1:0] run_q;
      always_ff @(posedge clk) begin
         if (rst) run_q <= INACT_LVL;
         else     run_q <= pins_i;
      end
      assign run_o = run_q;
   end else begin : g_comb
      assign run_o = live_q ? pins_i : INACT_LVL;
   end

endmodule

// File: rtl/strap_decode.sv
module strap_decode
   import strap_pkg::*;
(
   input  logic [PIN_MIN-1:0] held_i,
   input  logic               toggled_i,
   output strap_cfg_t         cfg_o
);

   logic st_n;
   logic hz_n;

   assign st_n = held_i[B_STEST_N];
   assign hz_n = held_i[B_HIZ_N];

   always_comb begin
      cfg_o              = '0;
      cfg_o.cfg_code     = held_i[B_CFG_LO +: B_CFG_W];
      cfg_o.drv_core     = held_i[B_DRV_C];
      cfg_o.drv_addr     = held_i[B_DRV_A];
      cfg_o.drv_data     = held_i[B_DRV_D];
      cfg_o.snoop_mode   = held_i[B_SNOOP];
      cfg_o.weak_order   = ~held_i[B_WORD_N];
      cfg_o.selftest_req = ~st_n &  hz_n;
      cfg_o.tristate_req = ~st_n & ~hz_n;
      cfg_o.io_x4        = held_i[B_X4];
      cfg_o.xfer_sel     = held_i[B_XFER];
      cfg_o.parity_mode  = ~held_i[B_PAR_N];
      cfg_o.mbus_clocked = toggled_i | ~held_i[B_MBUS];
      cfg_o.cfg_err      = held_i[B_CHK] | ~held_i[B_FLUSH];
   end

endmodule

// File: rtl/strap_sampler.sv
module strap_sampler
   import strap_pkg::*;
#(
   parameter int               N_PIN     = 16,
   parameter logic [N_PIN-1:0] INACT_LVL = 16'h7FFF,
   parameter bit               RUN_REG   = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_PIN-1:0] pins_i,
   output logic [N_PIN-1:0] run_pins_o,
   output logic [2:0]       cfg_code,
   output logic             drv_core,
   output logic             drv_addr,
   output logic             drv_data,
   output logic             snoop_mode,
   output logic             weak_order,
   output logic             selftest_req,
   output logic             tristate_req,
   output logic             io_x4,
   output logic             xfer_sel,
   output logic             parity_mode,
   output logic             mbus_clocked,
   output logic             cfg_err
);

   if (N_PIN < PIN_MIN) begin : g_bad_width
      $error("strap_sampler: N_PIN below strap count");
   end

   logic [PIN_MIN-1:0] held;
   logic               live;
   logic               toggled;
   strap_cfg_t         cfg;

   strap_capture #(.W(PIN_MIN)) u_cap (
      .clk    (clk),
      .rst    (rst),
      .pins_i (pins_i[PIN_MIN-1:0]),
      .held_o (held)
   );

   strap_handover #(
      .N_PIN     (N_PIN),
      .INACT_LVL (INACT_LVL),
      .RUN_REG   (RUN_REG)
   ) u_hand (
      .clk    (clk),
      .rst    (rst),
      .pins_i (pins_i),
      .live_o (live),
      .run_o  (run_pins_o)
   );

   strap_activity u_act (
      .clk       (clk),
      .rst       (rst),
      .live_i    (live),
      .pin_i     (pins_i[B_MBUS]),
      .toggled_o (toggled)
   );

   strap_decode u_dec (
      .held_i    (held),
      .toggled_i (toggled),
      .cfg_o     (cfg)
   );

   assign cfg_code     = cfg.cfg_code;
   assign drv_core     = cfg.drv_core;
   assign drv_addr     = cfg.drv_addr;
   assign drv_data     = cfg.drv_data;
   assign snoop_mode   = cfg.snoop_mode;
   assign weak_order   = cfg.weak_order;
   assign selftest_req = cfg.selftest_req;
   assign tristate_req = cfg.tristate_req;
   assign io_x4        = cfg.io_x4;
   assign xfer_sel     = cfg.xfer_sel;
   assign parity_mode  = cfg.parity_mode;
   assign mbus_clocked = cfg.mbus_clocked;
   assign cfg_err      = cfg.cfg_err;

endmodule

// File: rtl/strap_sampler_chk.sv
module strap_sampler_chk #(
   parameter int               N_PIN     = 16,
   parameter logic [N_PIN-1:0] INACT_LVL = 16'h7FFF,
   parameter bit               RUN_REG   = 1'b0
) (
   input logic             clk,
   input logic             rst,
   input logic [N_PIN-1:0] pins_i,
   input logic [N_PIN-1:0] run_pins_o,
   input logic [2:0]       cfg_code,
   input logic             weak_order,
   input logic             selftest_req,
   input logic             tristate_req,
   input logic             mbus_clocked,
   input logic             cfg_err
);

   logic        seen_q = 1'b0;
   logic        rst_q  = 1'b0;
   logic [15:0] cap_q;
   logic        tog_q;

   // independent model of the last reset sample and of the toggle flag
   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst) begin
         seen_q <= 1'b1;
         cap_q  <= pins_i[15:0];
         tog_q  <= rst_q ? (tog_q | (pins_i[11] != cap_q[11])) : 1'b0;
      end
   end

   // R1
   cfg_code_hold_chk: assert property (@(posedge clk) disable iff (rst)
      seen_q |-> cfg_code == cap_q[2:0]);

   // R3
   weak_order_chk: assert property (@(posedge clk) disable iff (rst)
      seen_q |-> weak_order == !cap_q[6]);

   // R4
   selftest_chk: assert property (@(posedge clk) disable iff (rst)
      seen_q |-> selftest_req == (!cap_q[7] && cap_q[8]));

   // R5
   tristate_chk: assert property (@(posedge clk) disable iff (rst)
      seen_q |-> tristate_req == (!cap_q[7] && !cap_q[8]));

   // R6
   mbus_mode_chk: assert property (@(posedge clk) disable iff (rst)
      seen_q |-> mbus_clocked == (tog_q || !cap_q[11]));

   // R8
   cfg_err_chk: assert property (@(posedge clk) disable iff (rst)
      seen_q |-> cfg_err == (cap_q[14] || !cap_q[15]));

   // R2
   run_gated_chk: assert property (@(posedge clk) disable iff (rst)
      seen_q && rst_q |-> run_pins_o == INACT_LVL);

   if (RUN_REG) begin : g_reg_chk
      // R2
      run_follow_chk: assert property (@(posedge clk) disable iff (rst)
         seen_q && !rst_q |-> run_pins_o == $past(pins_i));
   end else begin : g_comb_chk
      // R2
      run_follow_chk: assert property (@(posedge clk) disable iff (rst)
         seen_q && !rst_q |-> run_pins_o == pins_i);
   end

   // R9
   fields_stable_chk: assert property (@(posedge clk) disable iff (rst)
      seen_q && !rst_q |-> $stable(cfg_code) && $stable(mbus_clocked) && $stable(cfg_err));

endmodule

bind strap_sampler strap_sampler_chk #(
   .N_PIN     (N_PIN),
   .INACT_LVL (INACT_LVL),
   .RUN_REG   (RUN_REG)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .pins_i       (pins_i),
   .run_pins_o   (run_pins_o),
   .cfg_code     (cfg_code),
   .weak_order   (weak_order),
   .selftest_req (selftest_req),
   .tristate_req (tristate_req),
   .mbus_clocked (mbus_clocked),
   .cfg_err      (cfg_err)
);

// File: tb/strap_sampler_tb.sv
module strap_sampler_tb;

   localparam logic [15:0] INACT = 16'h7FFF;
   localparam int NVEC = 4;
   // {pins[15:0], toggle, expected[14:0]}
   // expected: [14:12] cfg, [11] weak, [10] st, [9] tri, [8] x4, [7] xfer,
   //           [6] par, [5] drvc, [4] drva, [3] drvd, [2] snoop, [1] mbclk, [0] err
   localparam logic [31:0] VEC [NVEC] = '{
      {16'hA9C5, 1'b0, 15'h5000},
      {16'h8F02, 1'b1, 15'h2DC2},
      {16'hF07F, 1'b0, 15'h723F},
      {16'h29C0, 1'b1, 15'h0003}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b0;
   logic [15:0] pins = 16'h0000;
   logic [15:0] run_pins;
   logic [2:0]  cfg_code;
   logic drv_core, drv_addr, drv_data, snoop_mode, weak_order, selftest_req;
   logic tristate_req, io_x4, xfer_sel, parity_mode, mbus_clocked, cfg_err;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   strap_sampler u_dut (
      .clk (clk), .rst (rst), .pins_i (pins), .run_pins_o (run_pins),
      .cfg_code (cfg_code), .drv_core (drv_core), .drv_addr (drv_addr),
      .drv_data (drv_data), .snoop_mode (snoop_mode), .weak_order (weak_order),
      .selftest_req (selftest_req), .tristate_req (tristate_req), .io_x4 (io_x4),
      .xfer_sel (xfer_sel), .parity_mode (parity_mode),
      .mbus_clocked (mbus_clocked), .cfg_err (cfg_err)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic chk_fields(input logic [14:0] e);
      chk("R1 cfg_code",     16'(cfg_code),     16'(e[14:12]));
      chk("R3 weak_order",   16'(weak_order),   16'(e[11]));
      chk("R4 selftest_req", 16'(selftest_req), 16'(e[10]));
      chk("R5 tristate_req", 16'(tristate_req), 16'(e[9]));
      chk("R7 misc fields",
          16'({io_x4, xfer_sel, parity_mode, drv_core, drv_addr, drv_data, snoop_mode}),
          16'(e[8:2]));
      chk("R6 mbus_clocked", 16'(mbus_clocked), 16'(e[1]));
      chk("R8 cfg_err",      16'(cfg_err),      16'(e[0]));
   endtask

   // hold reset with pins p for n_pre cycles, optionally flip bit 11 once,
   // then release reset and check fields, handover and stability
   task automatic run_reset(input logic [15:0] p, input logic tog,
                            input logic [14:0] e, input int n_pre);
      @(negedge clk);
      rst  = 1'b1;
      pins = p;
      repeat (n_pre) @(negedge clk);
      chk("R2 gated in reset", run_pins, INACT);
      if (tog) begin
         pins[11] = ~p[11];
         @(negedge clk);
         pins = p;
         repeat (2) @(negedge clk);
      end
      rst = 1'b0;
      #1;
      chk("R2 gated before handover", run_pins, INACT);
      chk_fields(e);
      @(negedge clk);
      chk("R2 follows after handover", run_pins, pins);
      pins = ~p;
      #1;
      chk("R2 follows new value", run_pins, ~p);
      @(negedge clk);
      @(negedge clk);
      // R9: fields unchanged after pins change
      chk_fields(e);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      pins = 16'hA9C5;
      repeat (2) @(negedge clk);
      for (int i = 0; i < NVEC; i++) begin
         run_reset(VEC[i][31:16], VEC[i][15], VEC[i][14:0], 3);
      end
      // R10: after the toggling reset of the last vector, a steady reset is strobed
      run_reset(16'hA9C5, 1'b0, 15'h5000, 3);
      // R6 corner: one-cycle reset gives a single sample and no toggle
      run_reset(16'hA9C5, 1'b0, 15'h5000, 1);
      // R6 corner: toggle then final low level is still clocked
      run_reset(16'h21C0, 1'b1, 15'h0003, 2);
      // R10: toggle followed by a steady-high reset reverts to strobed
      run_reset(16'h8F02, 1'b1, 15'h2DC2, 2);
      run_reset(16'h8F02, 1'b0, 15'h2DC0, 2);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule